// File: doc/BRIEF.md
# Packetized SPI Stream Engine

The engine takes fixed-size command packets as a byte stream and turns them into traffic on a bit-banged SPI port. Every packet opens with one command byte. A stream packet (0xA8) sends each of its payload bytes to the SPI port, and the byte clocked in during that exchange goes onto a reply byte stream. Each payload byte therefore yields one reply byte. A configuration packet (0xAA) switches the port between one data line and two data lines in each direction, and it also records a two-bit speed code that nothing else in the block uses. Any other leading byte makes the engine discard the rest of that packet.

Bits move least-significant first. A host that talks to an MSB-first device reverses the bit order of each byte before sending it. Positions that only read put 0xFF in the payload. Chip select, the transport that carries the packets and any other bus type are handled outside this block. The SCK half-period is a parameter counted in system clocks.

Top module: `spi_pkt_engine`

## Requirements
- R1: After reset sck is 0, dout and dout2 are 1, rep_valid is 0, cfg_dual is 0 and cfg_speed is 0.
- R2: In a packet whose first byte is 0xA8, each later byte is exchanged on the SPI port, and exactly one reply byte is produced for each of those bytes.
- R3: In single-line mode the byte goes out on dout bit 0 first, and the first bit sampled from din becomes bit 0 of the reply.
- R4: SCK idles low. dout changes only while SCK is low, and din is sampled on the rising edge. Each SCK level lasts DIV_HALF clocks, so two rising edges are never closer than 2*DIV_HALF clocks.
- R5: In dual mode a byte takes 4 SCK rising edges. Step k drives bit 2k on dout and bit 2k+1 on dout2, and it samples din into bit 2k and din2 into bit 2k+1.
- R6: A packet ends on a byte with in_last set, or on its PKT_LEN-th byte (command plus 31 payload bytes), whichever comes first. The byte that follows is taken as a new command byte.
- R7: In a packet starting with 0xAA, a second byte whose bits 7:3 are 01100 sets cfg_speed from bits 1:0 and cfg_dual from bit 2. Any other second byte leaves both unchanged. The rest of the packet is dropped without SCK activity.
- R8: A leading byte other than 0xA8 or 0xAA drops the whole packet, with no SCK edge and no reply.
- R9: While rep_valid is 1 and rep_ready is 0, rep_data stays stable, and no further payload byte starts shifting.
- R10: When no byte is shifting, dout and dout2 are 1. In single-line mode dout2 stays 1 while a byte shifts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_data | input | 8 | Packet byte stream data |
| in_valid | input | 1 | Packet byte present |
| in_last | input | 1 | Marks the final byte of a packet |
| in_ready | output | 1 | Engine accepts the current byte |
| rep_data | output | 8 | Received reply byte |
| rep_valid | output | 1 | Reply byte present |
| rep_ready | input | 1 | Consumer takes the reply byte |
| sck | output | 1 | SPI clock |
| dout | output | 1 | Primary data out |
| dout2 | output | 1 | Secondary data out (dual mode) |
| din | input | 1 | Primary data in |
| din2 | input | 1 | Secondary data in (dual mode) |
| cfg_speed | output | 2 | Stored speed code |
| cfg_dual | output | 1 | Dual data-line mode selected |

## Verification
The bench builds the engine with DIV_HALF=2 and PKT_LEN=32. The short SCK half-period keeps each byte at 32 clocks, so a complete 31-byte packet, the packet-length cutoff and the edge-spacing check all fit in a short run. The SPI inputs are wired to the inverted outputs. Each reply must then be the complement of its payload, and a monitor records the dout/dout2 bits at every SCK rise to check the bit order in both widths.

// File: rtl/spi_pkt_pkg.sv
package spi_pkt_pkg;
  localparam logic [7:0] CMD_STREAM = 8'hA8;
  localparam logic [7:0] CMD_CONFIG = 8'hAA;
  localparam logic [4:0] CFG_TAG    = 5'b01100;

  typedef enum logic [1:0] {
    PS_CMD,
    PS_STREAM,
    PS_CFG,
    PS_DROP
  } pstate_t;
endpackage

// File: rtl/spi_pkt_parser.sv
module spi_pkt_parser
  import spi_pkt_pkg::*;
#(
  parameter int PKT_LEN = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  input  logic       in_last,
  output logic       in_ready,
  input  logic       shift_busy,
  input  logic       reply_full,
  output logic       start,
  output logic [7:0] start_byte,
  output logic       cfg_dual,
  output logic [1:0] cfg_speed
);
  localparam int PW = $clog2(PKT_LEN);

  pstate_t        state_q, state_d;
  logic [PW-1:0]  pos_q, pos_d;
  logic           dual_q, dual_d;
  logic [1:0]     speed_q, speed_d;
  logic           acc, pkt_end, cfg_we;

  always_comb begin
    in_ready   = (state_q == PS_STREAM) ? (!shift_busy && !reply_full) : 1'b1;
    acc        = in_valid && in_ready;
    pkt_end    = in_last || (pos_q == PW'(PKT_LEN - 1));
    start      = acc && (state_q == PS_STREAM);
    start_byte = in_data;
    cfg_we     = acc && (state_q == PS_CFG) && (in_data[7:3] == CFG_TAG);

    state_d = state_q;
    pos_d   = pos_q;
    if (acc) begin
      if (pkt_end) begin
        state_d = PS_CMD;
        pos_d   = '0;
      end else begin
        pos_d = pos_q + 1'b1;
        case (state_q)
          PS_CMD: begin
            if (in_data == CMD_STREAM)      state_d = PS_STREAM;
            else if (in_data == CMD_CONFIG) state_d = PS_CFG;
            else                            state_d = PS_DROP;
          end
          PS_CFG:  state_d = PS_DROP;
          default: state_d = state_q;
        endcase
      end
    end

    dual_d  = cfg_we ? in_data[2]   : dual_q;
    speed_d = cfg_we ? in_data[1:0] : speed_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PS_CMD;
      pos_q   <= '0;
      dual_q  <= 1'b0;
      speed_q <= 2'd0;
    end else begin
      state_q <= state_d;
      pos_q   <= pos_d;
      dual_q  <= dual_d;
      speed_q <= speed_d;
    end
  end

  assign cfg_dual  = dual_q;
  assign cfg_speed = speed_q;

  // R6: a packet boundary always returns to command parsing
  p_end_to_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc && pkt_end |=> state_q == PS_CMD);
  // R8: a dropped packet never launches a shift
  p_drop_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_DROP || state_q == PS_CFG) |-> !start);
  // R7: configuration only changes through the configuration packet
  p_cfg_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(state_q) != PS_CFG |-> $stable(cfg_dual) && $stable(cfg_speed));
endmodule

// File: rtl/spi_pkt_shifter.sv
module spi_pkt_shifter #(
  parameter int DIV_HALF = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  logic       dual_in,
  input  logic       din,
  input  logic       din2,
  output logic       busy,
  output logic       done,
  output logic [7:0] rx_byte,
  output logic       sck,
  output logic       dout,
  output logic       dout2
);
  localparam int DW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

  logic          busy_q, busy_d;
  logic          sck_q, sck_d;
  logic [DW-1:0] div_q, div_d;
  logic [2:0]    step_q, step_d;
  logic [7:0]    tx_q, tx_d;
  logic [7:0]    rx_q, rx_d;
  logic          dual_q, dual_d;
  logic          tick;
  logic [2:0]    last_step;

  always_comb begin
    tick      = busy_q && (div_q == DW'(DIV_HALF - 1));
    last_step = dual_q ? 3'd3 : 3'd7;
    done      = tick && sck_q && (step_q == last_step);

    busy_d = busy_q;
    sck_d  = sck_q;
    div_d  = div_q;
    step_d = step_q;
    tx_d   = tx_q;
    rx_d   = rx_q;
    dual_d = dual_q;
    if (start && !busy_q) begin
      busy_d = 1'b1;
      sck_d  = 1'b0;
      div_d  = '0;
      step_d = '0;
      tx_d   = tx_byte;
      dual_d = dual_in;
    end else if (tick) begin
      div_d = '0;
      sck_d = !sck_q;
      if (!sck_q) begin
        rx_d = dual_q ? {din2, din, rx_q[7:2]} : {din, rx_q[7:1]};
      end else begin
        tx_d   = dual_q ? {2'b11, tx_q[7:2]} : {1'b1, tx_q[7:1]};
        step_d = step_q + 1'b1;
        if (done) busy_d = 1'b0;
      end
    end else if (busy_q) begin
      div_d = div_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      div_q  <= '0;
      step_q <= '0;
      tx_q   <= '1;
      rx_q   <= '0;
      dual_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      sck_q  <= sck_d;
      div_q  <= div_d;
      step_q <= step_d;
      tx_q   <= tx_d;
      rx_q   <= rx_d;
      dual_q <= dual_d;
    end
  end

  assign busy    = busy_q;
  assign rx_byte = rx_q;
  assign sck     = sck_q;
  assign dout    = busy_q ? tx_q[0] : 1'b1;
  assign dout2   = (busy_q && dual_q) ? tx_q[1] : 1'b1;

  // R4: SCK rests low between bytes
  p_sck_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !sck_q);
  // R4: outgoing data holds while SCK is high
  p_data_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sck_q && $past(sck_q) |-> $stable(dout) && $stable(dout2));
  // R9: a new byte only starts once the previous one is finished
  p_start_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy_q);
  // R10: secondary output stays high in single-line mode
  p_dout2_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !dual_q |-> dout2);
endmodule

// File: rtl/spi_pkt_reply.sv
module spi_pkt_reply (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] load_data,
  input  logic       rep_ready,
  output logic       rep_valid,
  output logic [7:0] rep_data
);
  logic       valid_q, valid_d;
  logic [7:0] data_q, data_d;

  always_comb begin
    valid_d = valid_q;
    data_d  = data_q;
    if (valid_q && rep_ready) valid_d = 1'b0;
    if (load) begin
      valid_d = 1'b1;
      data_d  = load_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= valid_d;
      data_q  <= data_d;
    end
  end

  assign rep_valid = valid_q;
  assign rep_data  = data_q;

  // R9: a stalled reply keeps its value
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rep_valid && !rep_ready |=> rep_valid && $stable(rep_data));
  // R2: no reply is overwritten before it is taken
  p_no_clobber_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !valid_q);
endmodule

// File: rtl/spi_pkt_engine.sv
module spi_pkt_engine #(
  parameter int DIV_HALF = 2,
  parameter int PKT_LEN  = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  input  logic       in_last,
  output logic       in_ready,
  output logic [7:0] rep_data,
  output logic       rep_valid,
  input  logic       rep_ready,
  output logic       sck,
  output logic       dout,
  output logic       dout2,
  input  logic       din,
  input  logic       din2,
  output logic [1:0] cfg_speed,
  output logic       cfg_dual
);
  logic       shift_busy, shift_done, start;
  logic [7:0] start_byte, rx_byte;

  spi_pkt_parser #(.PKT_LEN(PKT_LEN)) u_parser (
    .clk(clk), .rst_n(rst_n),
    .in_data(in_data), .in_valid(in_valid), .in_last(in_last), .in_ready(in_ready),
    .shift_busy(shift_busy), .reply_full(rep_valid),
    .start(start), .start_byte(start_byte),
    .cfg_dual(cfg_dual), .cfg_speed(cfg_speed)
  );

  spi_pkt_shifter #(.DIV_HALF(DIV_HALF)) u_shifter (
    .clk(clk), .rst_n(rst_n),
    .start(start), .tx_byte(start_byte), .dual_in(cfg_dual),
    .din(din), .din2(din2),
    .busy(shift_busy), .done(shift_done), .rx_byte(rx_byte),
    .sck(sck), .dout(dout), .dout2(dout2)
  );

  spi_pkt_reply u_reply (
    .clk(clk), .rst_n(rst_n),
    .load(shift_done), .load_data(rx_byte),
    .rep_ready(rep_ready), .rep_valid(rep_valid), .rep_data(rep_data)
  );
endmodule

// File: tb/spi_pkt_engine_bench.sv
module spi_pkt_engine_bench;
  localparam int DIV_HALF = 2;
  localparam int PKT_LEN  = 32;
  localparam int NVEC = 8;
  // {dual mode, payload byte}
  localparam logic [8:0] VEC [NVEC] = '{
    9'h000, 9'h0FF, 9'h001, 9'h080, 9'h0A5, 9'h15A, 9'h181, 9'h13C
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] in_data = '0;
  logic in_valid = 1'b0, in_last = 1'b0, rep_ready = 1'b1;
  logic in_ready, rep_valid, sck, dout, dout2, cfg_dual;
  logic [7:0] rep_data;
  logic [1:0] cfg_speed;
  logic din, din2;

  assign din  = ~dout;
  assign din2 = ~dout2;

  always #2 clk = ~clk;

  spi_pkt_engine #(.DIV_HALF(DIV_HALF), .PKT_LEN(PKT_LEN)) u_spi_pkt_engine (
    .clk(clk), .rst_n(rst_n),
    .in_data(in_data), .in_valid(in_valid), .in_last(in_last), .in_ready(in_ready),
    .rep_data(rep_data), .rep_valid(rep_valid), .rep_ready(rep_ready),
    .sck(sck), .dout(dout), .dout2(dout2), .din(din), .din2(din2),
    .cfg_speed(cfg_speed), .cfg_dual(cfg_dual)
  );

  int checks = 0, failures = 0;
  int rises = 0, bad_hold = 0, bad_gap = 0, gap = 0;
  int rep_n = 0;
  logic [7:0] rep_log [0:63];
  logic [7:0] cap = '0;
  logic mon_dual = 1'b0;
  logic prev_sck = 1'b0, prev_dout = 1'b1, prev_dout2 = 1'b1;

  always @(negedge clk) begin
    gap <= gap + 1;
    if (sck && !prev_sck) begin
      rises <= rises + 1;
      cap <= mon_dual ? {dout2, dout, cap[7:2]} : {dout, cap[7:1]};
      if (rises > 0 && gap + 1 < 2 * DIV_HALF) bad_gap <= bad_gap + 1;
      gap <= 0;
    end
    if (sck && prev_sck && (dout != prev_dout || dout2 != prev_dout2)) bad_hold <= bad_hold + 1;
    prev_sck <= sck; prev_dout <= dout; prev_dout2 <= dout2;
  end

  always @(posedge clk) begin
    if (rep_valid && rep_ready) begin
      if (rep_n < 64) rep_log[rep_n] <= rep_data;
      rep_n <= rep_n + 1;
    end
  end

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b, input logic last);
    @(negedge clk);
    in_data = b; in_last = last; in_valid = 1'b1;
    do @(posedge clk); while (!in_ready);
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic wait_replies(input int n);
    for (int i = 0; i < 3000 && rep_n < n; i++) @(negedge clk);
  endtask

  task automatic set_mode(input logic dual);
    send(8'hAA, 1'b0);
    send({5'b01100, dual, 2'b00}, 1'b0);
    send(8'h00, 1'b1);
    mon_dual = dual;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int r0, n0;
    logic [7:0] b;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(sck == 1'b0 && dout && dout2, "R1 pins", {sck, dout, dout2}, 3'b011);
    check(!rep_valid && !cfg_dual && cfg_speed == 2'd0, "R1 state",
          {rep_valid, cfg_dual, cfg_speed}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Vector walk: one byte per packet in each mode
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][8] != mon_dual) set_mode(VEC[i][8]);
      b  = VEC[i][7:0];
      r0 = rises; n0 = rep_n;
      send(8'hA8, 1'b0);
      send(b, 1'b1);
      wait_replies(n0 + 1);
      repeat (4) @(negedge clk);
      check(rep_n == n0 + 1 && rep_log[n0] == ~b, "R2 reply", rep_log[n0], ~b);
      if (mon_dual) begin
        check(cap == b, "R5 dual bit order", cap, b);
        check(rises - r0 == 4, "R5 dual edges", rises - r0, 4);
      end else begin
        check(cap == b, "R3 lsb first", cap, b);
        check(rises - r0 == 8, "R4 single edges", rises - r0, 8);
      end
      check(dout && dout2 && !sck, "R10 idle pins", {sck, dout, dout2}, 3'b011);
    end
    set_mode(1'b0);
    check(!cfg_dual && cfg_speed == 2'd0, "R7 back to single", {cfg_dual, cfg_speed}, 0);

    // R6 full packet of 31 payload bytes without last, then a new packet
    r0 = rises; n0 = rep_n;
    send(8'hA8, 1'b0);
    for (int k = 1; k <= PKT_LEN - 1; k++) send(8'(k * 7), 1'b0);
    wait_replies(n0 + PKT_LEN - 1);
    repeat (4) @(negedge clk);
    check(rep_n - n0 == PKT_LEN - 1, "R6 full packet replies", rep_n - n0, PKT_LEN - 1);
    check(rep_log[n0 + PKT_LEN - 2] == ~8'((PKT_LEN - 1) * 7), "R6 last payload",
          rep_log[n0 + PKT_LEN - 2], ~8'((PKT_LEN - 1) * 7));
    r0 = rises; n0 = rep_n;
    // R8 next byte is a command: unknown, so the packet is dropped
    send(8'h55, 1'b0);
    send(8'h12, 1'b0);
    send(8'h34, 1'b1);
    repeat (60) @(negedge clk);
    check(rises == r0, "R8 no sck on unknown command", rises - r0, 0);
    check(rep_n == n0, "R8 no reply on unknown command", rep_n - n0, 0);
    send(8'hA8, 1'b0);
    send(8'h42, 1'b1);
    wait_replies(n0 + 1);
    check(rep_n == n0 + 1 && rep_log[n0] == 8'hBD, "R6 recovery after drop", rep_log[n0], 8'hBD);

    // R7 configuration handling
    r0 = rises;
    send(8'hAA, 1'b0); send(8'h12, 1'b0); send(8'h00, 1'b1);
    repeat (4) @(negedge clk);
    check(!cfg_dual && cfg_speed == 2'd0, "R7 bad tag ignored", {cfg_dual, cfg_speed}, 0);
    send(8'hAA, 1'b0); send(8'h67, 1'b0); send(8'h00, 1'b1);
    repeat (2) @(negedge clk);
    check(cfg_dual && cfg_speed == 2'd3, "R7 dual speed3", {cfg_dual, cfg_speed}, 3'b111);
    send(8'hAA, 1'b0); send(8'h61, 1'b1);
    repeat (2) @(negedge clk);
    check(!cfg_dual && cfg_speed == 2'd1, "R7 single speed1", {cfg_dual, cfg_speed}, 3'b001);
    check(rises == r0, "R7 no sck in config", rises - r0, 0);

    // R9 backpressure
    rep_ready = 1'b0;
    r0 = rises; n0 = rep_n;
    send(8'hA8, 1'b0);
    send(8'hC3, 1'b0);
    repeat (100) @(negedge clk);
    check(rep_valid && rep_data == 8'h3C, "R9 reply held", rep_data, 8'h3C);
    fork
      send(8'h0F, 1'b1);
      begin
        repeat (60) @(negedge clk);
        check(rises - r0 == 8, "R9 no second byte while stalled", rises - r0, 8);
        check(rep_valid && rep_data == 8'h3C, "R9 reply still stable", rep_data, 8'h3C);
        rep_ready = 1'b1;
      end
    join
    wait_replies(n0 + 2);
    check(rep_n == n0 + 2 && rep_log[n0 + 1] == 8'hF0, "R9 second reply", rep_log[n0 + 1], 8'hF0);

    repeat (4) @(negedge clk);
    check(bad_hold == 0, "R4 data stable while sck high", bad_hold, 0);
    check(bad_gap == 0, "R4 sck half period", bad_gap, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule